// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Controller

This block sits between a two-wire bus slave's protocol engine and a 256-word by 8-bit storage array. The protocol engine hands it a word-address strobe, then one strobe per received data byte, and finally a STOP or an abort (a START that breaks into the transfer). Data bytes are gathered in a small page buffer whose slot is chosen by the low address bits. Nothing reaches the array until STOP. At STOP, the buffered bytes are copied into the array inside a fixed busy window of system clocks, and the protocol engine sees that window on the busy output.

Each accepted strobe returns a one-cycle acknowledge, which the protocol engine turns into the bus ACK bit. A write-protect input makes the block refuse data bytes. The word address is still taken, so a later read can start from it. The shared address pointer follows the word address when one is loaded. After a commit it is left on the last byte written, so a following current-address read continues from the next location.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, busy_o, ack_o and mem_we_o are 0 and ptr_o is 0.
- R2: While busy_o is 0, an address strobe is acknowledged (ack_o high for one cycle, in the cycle after the strobe) whatever wp_i is, and ptr_o takes the strobed address in that same cycle.
- R3: Data bytes fill the page selected by the upper 5 address bits. The first byte goes to the low 3 bits of the word address, and each following byte goes to the next offset modulo 8. The upper 5 bits never change within a transfer.
- R4: When more than 8 data bytes arrive before STOP, the offset wraps and a later byte replaces the earlier byte at the same offset. Only the final value of each offset is written.
- R5: No array write happens before STOP. mem_we_o is only high while busy_o is high.
- R6: A STOP after at least one accepted data byte raises busy_o in the next cycle and holds it for exactly WR_CYCLES cycles. Each received offset is written once, inside that window.
- R7: Page locations that received no byte in the transfer keep their contents.
- R8: While busy_o is high, address, data, STOP and abort strobes get no acknowledge and have no effect, including on ptr_o.
- R9: A data byte that arrives while wp_i is 1 gets no acknowledge, and neither do the later bytes of the same transfer. The following STOP starts no busy window and writes nothing.
- R10: A STOP with no data bytes received, or an abort strobe, starts no busy window, writes nothing and discards the buffered bytes. A later transfer writes only its own bytes.
- R11: At the end of a commit, ptr_o holds the address of the last data byte received.
- R12: A data strobe that arrives with no word address loaded since the last STOP or abort gets no acknowledge and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld_i | input | 1 | Word-address strobe from the protocol engine |
| addr_i | input | 8 | Word address that goes with addr_vld_i |
| data_vld_i | input | 1 | Data-byte strobe |
| data_i | input | 8 | Data byte that goes with data_vld_i |
| stop_i | input | 1 | STOP seen on the bus |
| abort_i | input | 1 | START that interrupts the transfer |
| wp_i | input | 1 | Write protect, 1 = data bytes are refused |
| busy_o | output | 1 | Commit window active |
| ack_o | output | 1 | One-cycle acknowledge of the previous cycle's strobe |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| ptr_o | output | 8 | Shared address pointer |

## Verification
On every cycle, the assertions check the following: array writes fall inside the busy window, no acknowledge is given for a strobe seen during busy, every busy window lasts exactly the configured length, and the page address stays fixed for the whole window. Only the bench's scenarios can show which bytes end up where: the wrap order inside a page, untouched neighbour locations, write-protect and abort discarding a page, and the pointer value after a commit. The bench shows these by keeping a copy of the array fed only from the write port and comparing it with the values the requirements predict.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      PW_IDLE  = 2'd0,
      PW_FILL  = 2'd1,
      PW_BLOCK = 2'd2,
      PW_FLUSH = 2'd3
   } pw_state_e;
endpackage

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
   parameter int WR_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(WR_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start_i)
         cnt_q <= CNT_W'(WR_CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 8,
   parameter int OFS_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic [OFS_W-1:0]  wr_ofs_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [OFS_W-1:0]  rd_ofs_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_vld_o
);
   logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] slot_vld;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic [DATA_W-1:0] d_q;
      logic              v_q;
      logic              hit;

      assign hit = wr_i && (wr_ofs_i == OFS_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else if (hit) begin
            d_q <= wr_data_i;
            v_q <= 1'b1;
         end else if (clr_i) begin
            v_q <= 1'b0;
         end
      end

      assign slot_data[g] = d_q;
      assign slot_vld[g]  = v_q;
   end

   assign rd_data_o = slot_data[rd_ofs_i];
   assign rd_vld_o  = slot_vld[rd_ofs_i];
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
   import pgwr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 8,
   parameter int OFS_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              data_vld_i,
   input  logic              stop_i,
   input  logic              abort_i,
   input  logic              wp_i,
   input  logic              busy_i,
   input  logic              slot_vld_i,
   output logic              ack_o,
   output logic              buf_clr_o,
   output logic              buf_wr_o,
   output logic [OFS_W-1:0]  fill_ofs_o,
   output logic [OFS_W-1:0]  scan_ofs_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              tmr_start_o
);
   localparam int PAGE_W = ADDR_W - OFS_W;
   localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

   pw_state_e         state_q, state_d;
   logic [PAGE_W-1:0] page_q, page_d;
   logic [OFS_W-1:0]  fill_q, fill_d;
   logic [OFS_W-1:0]  last_q, last_d;
   logic [OFS_W-1:0]  scan_q, scan_d;
   logic              got_q, got_d;
   logic [ADDR_W-1:0] ptr_q, ptr_d;
   logic              ack_q, ack_d;
   logic              clr, wr, start;

   always_comb begin
      state_d = state_q;
      page_d  = page_q;
      fill_d  = fill_q;
      last_d  = last_q;
      scan_d  = scan_q;
      got_d   = got_q;
      ptr_d   = ptr_q;
      ack_d   = 1'b0;
      clr     = 1'b0;
      wr      = 1'b0;
      start   = 1'b0;

      if (state_q == PW_FLUSH) begin
         scan_d = scan_q + 1'b1;
         if (scan_q == LAST_OFS) begin
            state_d = PW_IDLE;
            ptr_d   = {page_q, last_q};
            got_d   = 1'b0;
            clr     = 1'b1;
         end
      end else if (!busy_i) begin
         if (abort_i) begin
            state_d = PW_IDLE;
            got_d   = 1'b0;
            clr     = 1'b1;
         end else if (stop_i) begin
            if (state_q == PW_FILL && got_q) begin
               state_d = PW_FLUSH;
               scan_d  = '0;
               start   = 1'b1;
            end else begin
               state_d = PW_IDLE;
               got_d   = 1'b0;
               clr     = 1'b1;
            end
         end else if (addr_vld_i) begin
            state_d = PW_FILL;
            page_d  = addr_i[ADDR_W-1:OFS_W];
            fill_d  = addr_i[OFS_W-1:0];
            ptr_d   = addr_i;
            got_d   = 1'b0;
            clr     = 1'b1;
            ack_d   = 1'b1;
         end else if (data_vld_i && state_q == PW_FILL) begin
            if (wp_i) begin
               state_d = PW_BLOCK;
            end else begin
               wr     = 1'b1;
               last_d = fill_q;
               fill_d = fill_q + 1'b1;
               got_d  = 1'b1;
               ack_d  = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PW_IDLE;
         page_q  <= '0;
         fill_q  <= '0;
         last_q  <= '0;
         scan_q  <= '0;
         got_q   <= 1'b0;
         ptr_q   <= '0;
         ack_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         page_q  <= page_d;
         fill_q  <= fill_d;
         last_q  <= last_d;
         scan_q  <= scan_d;
         got_q   <= got_d;
         ptr_q   <= ptr_d;
         ack_q   <= ack_d;
      end
   end

   assign ack_o       = ack_q;
   assign buf_clr_o   = clr;
   assign buf_wr_o    = wr;
   assign fill_ofs_o  = fill_q;
   assign scan_ofs_o  = scan_q;
   assign mem_we_o    = (state_q == PW_FLUSH) && slot_vld_i;
   assign mem_addr_o  = {page_q, scan_q};
   assign ptr_o       = ptr_q;
   assign tmr_start_o = start;
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 8,
   parameter int WR_CYCLES  = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              data_vld_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              stop_i,
   input  logic              abort_i,
   input  logic              wp_i,
   output logic              busy_o,
   output logic              ack_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam int OFS_W = $clog2(PAGE_BYTES);

   if (PAGE_BYTES < 2 || (1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end
   if (WR_CYCLES <= PAGE_BYTES) begin : g_bad_window
      $error("WR_CYCLES must exceed PAGE_BYTES so the flush fits the window");
   end

   logic             buf_clr, buf_wr, slot_vld, tmr_start;
   logic [OFS_W-1:0] fill_ofs, scan_ofs;

   pgwr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tmr_start),
      .busy_o  (busy_o)
   );

   pgwr_buffer #(
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES),
      .OFS_W      (OFS_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (buf_clr),
      .wr_i      (buf_wr),
      .wr_ofs_i  (fill_ofs),
      .wr_data_i (data_i),
      .rd_ofs_i  (scan_ofs),
      .rd_data_o (mem_wdata_o),
      .rd_vld_o  (slot_vld)
   );

   pgwr_seq #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .OFS_W      (OFS_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_vld_i  (addr_vld_i),
      .addr_i      (addr_i),
      .data_vld_i  (data_vld_i),
      .stop_i      (stop_i),
      .abort_i     (abort_i),
      .wp_i        (wp_i),
      .busy_i      (busy_o),
      .slot_vld_i  (slot_vld),
      .ack_o       (ack_o),
      .buf_clr_o   (buf_clr),
      .buf_wr_o    (buf_wr),
      .fill_ofs_o  (fill_ofs),
      .scan_ofs_o  (scan_ofs),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .ptr_o       (ptr_o),
      .tmr_start_o (tmr_start)
   );
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
   parameter int ADDR_W    = 8,
   parameter int OFS_W     = 3,
   parameter int WR_CYCLES = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              ack_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o
);
   int run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 0;
      else if (busy_o)
         run_q <= run_q + 1;
      else
         run_q <= 0;
   end

   // R5
   we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o);

   // R8
   no_busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_o) |-> !ack_o);

   // R6
   window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(busy_o)) |-> (run_q == WR_CYCLES));

   // R3
   page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFS_W]));
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .OFS_W     (OFS_W),
   .WR_CYCLES (WR_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .ack_o      (ack_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o)
);

// File: tb/pgwr_ctrl_tb.sv
module pgwr_ctrl_tb;
   localparam int W = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_vld = 1'b0, data_vld = 1'b0, stop = 1'b0, abort = 1'b0, wp = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic       busy, ack, we;
   logic [7:0] maddr, mwdata, ptr;

   logic [7:0] mem [256];
   logic [7:0] exp [256];
   int checks = 0, errors = 0, wr_cnt = 0, done = 0;

   always #2.5 clk = ~clk;

   pgwr_ctrl #(.WR_CYCLES(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_vld_i(addr_vld), .addr_i(addr),
      .data_vld_i(data_vld), .data_i(wdata), .stop_i(stop), .abort_i(abort),
      .wp_i(wp), .busy_o(busy), .ack_o(ack), .mem_we_o(we),
      .mem_addr_o(maddr), .mem_wdata_o(mwdata), .ptr_o(ptr)
   );

   always @(posedge clk) begin
      if (rst_n && we) begin
         mem[maddr] <= mwdata;
         wr_cnt = wr_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic chk_page(input string req, input logic [7:0] base);
      for (int i = 0; i < 8; i++) chk(req, mem[base + 8'(i)], exp[base + 8'(i)]);
   endtask

   task automatic put_addr(input logic [7:0] a, input logic exp_ack, input string req);
      @(negedge clk); addr_vld = 1'b1; addr = a;
      @(negedge clk); addr_vld = 1'b0;
      chk(req, ack, exp_ack);
   endtask

   task automatic put_data(input logic [7:0] d, input logic exp_ack, input string req);
      @(negedge clk); data_vld = 1'b1; wdata = d;
      @(negedge clk); data_vld = 1'b0;
      chk(req, ack, exp_ack);
   endtask

   task automatic put_stop();
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 0);
      chk("R1 ack", ack, 0);
      chk("R1 we", we, 0);
      chk("R1 ptr", ptr, 0);
   endtask

   task automatic t_byte_write();
      int n, w0;
      w0 = wr_cnt;
      put_addr(8'h13, 1, "R2 addr ack");
      chk("R2 ptr", ptr, 8'h13);
      put_data(8'hA1, 1, "R6 data ack");
      chk("R5 no write before stop", wr_cnt, w0);
      exp[8'h13] = 8'hA1;
      put_stop();
      wait_idle(n);
      chk("R6 busy length", n, W);
      chk("R6 write count", wr_cnt - w0, 1);
      chk_page("R7 byte page", 8'h10);
      chk("R11 ptr byte", ptr, 8'h13);
   endtask

   task automatic t_page_wrap();
      int n, w0;
      w0 = wr_cnt;
      put_addr(8'h2E, 1, "R2 addr ack");
      for (int i = 0; i < 10; i++) begin
         put_data(8'hD0 + 8'(i), 1, "R4 data ack");
         exp[{5'h05, 3'(6 + i)}] = 8'hD0 + 8'(i);
      end
      chk("R5 no write before stop", wr_cnt, w0);
      put_stop();
      chk("R6 busy raised", busy, 1);
      put_addr(8'h99, 0, "R8 addr during busy");
      put_data(8'h55, 0, "R8 data during busy");
      wait_idle(n);
      chk("R4 write count", wr_cnt - w0, 8);
      chk_page("R4 wrap page", 8'h28);
      chk("R3 upper page untouched", mem[8'h30], exp[8'h30]);
      chk("R11 ptr wrap", ptr, 8'h2F);
   endtask

   task automatic t_partial();
      int n, w0;
      w0 = wr_cnt;
      put_addr(8'h46, 1, "R2 addr ack");
      for (int i = 0; i < 4; i++) begin
         put_data(8'hB0 + 8'(i), 1, "R3 data ack");
         exp[{5'h08, 3'(6 + i)}] = 8'hB0 + 8'(i);
      end
      put_stop();
      wait_idle(n);
      chk("R6 partial busy length", n, W);
      chk("R3 write count", wr_cnt - w0, 4);
      chk_page("R7 partial page", 8'h40);
      chk("R11 ptr partial", ptr, 8'h41);
   endtask

   task automatic t_wp();
      int n, w0;
      w0 = wr_cnt;
      wp = 1'b1;
      put_addr(8'h80, 1, "R2 addr ack under wp");
      chk("R2 ptr under wp", ptr, 8'h80);
      put_data(8'hEE, 0, "R9 first data nack");
      put_data(8'hEF, 0, "R9 second data nack");
      put_stop();
      chk("R9 no busy", busy, 0);
      repeat (W + 2) @(negedge clk);
      chk("R9 no writes", wr_cnt, w0);
      chk_page("R9 page unchanged", 8'h80);
      wp = 1'b0;
   endtask

   task automatic t_empty_abort();
      int n, w0;
      w0 = wr_cnt;
      put_addr(8'h50, 1, "R2 addr ack");
      put_stop();
      chk("R10 empty stop no busy", busy, 0);
      put_addr(8'h60, 1, "R2 addr ack");
      put_data(8'h11, 1, "R10 data ack");
      put_data(8'h22, 1, "R10 data ack");
      @(negedge clk); abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      put_stop();
      chk("R10 abort no busy", busy, 0);
      put_data(8'h33, 0, "R12 orphan data nack");
      put_stop();
      chk("R12 no busy", busy, 0);
      chk("R10 no writes", wr_cnt, w0);
      put_addr(8'h72, 1, "R2 addr ack");
      put_data(8'h77, 1, "R10 data ack");
      exp[8'h72] = 8'h77;
      put_stop();
      wait_idle(n);
      chk("R10 only new byte", wr_cnt - w0, 1);
      chk_page("R10 old page", 8'h60);
      chk_page("R10 new page", 8'h70);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i) ^ 8'h5A;
         exp[i] = 8'(i) ^ 8'h5A;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_byte_write();
      t_page_wrap();
      t_partial();
      t_wp();
      t_empty_abort();
      if (done == 0) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(5 * 150000);
      if (done == 0) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule